// File: doc/BRIEF.md
# Scanline sprite evaluator

This block decides which sprites appear on the next scanline and turns each of them into a draw entry. It keeps a private 64-byte copy of the sprite Y coordinates. The copy is filled by watching the ordinary video-memory write stream for writes that land in the Y area of the sprite table. When `start` is pulsed, the block compares the Y bytes against line `line_cur + 1` (wrapping at 256). It compares two table entries per clock and records the index and Y of each sprite it finds, up to `HITS` of them.

Once the scan ends, a fetch phase goes through the recorded sprites in scan order. For each one it reads the X byte and the pattern-index byte through a byte-wide read port with one cycle of latency. It then emits a draw entry that holds the X position and the memory address of the pattern row to draw. Only `DRAWS` entries can be emitted. If a recorded sprite is still waiting when the draw list is full, the overflow flag is set. Drawing pixels from the list is left to the next stage.

The control is a state machine with these states:
- ST_IDLE: waits after reset.
- ST_SCAN: compares two entries per cycle.
- ST_RD_X: issues the X read.
- ST_RD_PAT: captures X and issues the pattern read.
- ST_EMIT: drives the draw entry.
- ST_DONE: holds the result.

Its transitions are:
- From any state, `start` goes to ST_SCAN.
- ST_SCAN goes to ST_DONE when the scan ends with no hits, and to ST_RD_X when it ends with hits.
- ST_RD_X goes to ST_RD_PAT, and ST_RD_PAT goes to ST_EMIT.
- ST_EMIT goes back to ST_RD_X while more recorded sprites remain and the draw list has room.
- Otherwise ST_EMIT goes to ST_DONE, setting the overflow flag if recorded sprites remain.

Top module: `sprite_line_eval`

## Requirements
- R1: The line compared is `(line_cur + 1) mod 256`, latched when `start` is pulsed; `line_cur = 255` compares against line 0.
- R2: The sprite height is 16 when `tall` is 1 and 8 when `tall` is 0.
- R3: Entry i hits when `y <= L < y + height`, with L the compared line and the sum taken without wrap. The draw row address is `pattern*32 + (L - y)*4`.
- R4: Each scan cycle examines entries i and i+1 in table order. Hits are recorded in table order until `HITS` are held, and later entries are not examined.
- R5: A Y byte of 0xD0 ends the scan; neither it nor any later entry is recorded.
- R6: The table base is address `{tbl_reg[6:1], 8'h00}`; bits 7 and 0 of `tbl_reg` are ignored. A snooped write with address in base..base+63 updates Y cache entry `addr[5:0]`. Any other address leaves the cache unchanged.
- R7: For recorded sprite index n, X is read at `base + 0x80 + 2n` and the pattern index at `base + 0x81 + 2n`. Read data returns on the cycle after `rd_en`. Draw entries come out with `dl_we`, numbered in `dl_slot` from 0 in scan order.
- R8: `dl_row` adds 0x2000 when `pat_reg[2]` is 1; the other bits of `pat_reg` have no effect.
- R9: At most `DRAWS` entries are emitted. When a recorded sprite remains after the list is full, `overflow` is set and stays set until the next `start`.
- R10: `start` restarts evaluation from entry 0 in any state. It clears the recorded hits, the draw count, `overflow` and `done`.
- R11: Reset clears every Y cache byte to 0, returns to idle, and drives `done`, `overflow`, `rd_en` and `dl_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin evaluation for the next line |
| line_cur | input | 8 | Current line number |
| tbl_reg | input | 8 | Sprite table base; bits 6:1 give address bits 13:8 |
| pat_reg | input | 8 | Pattern base; bit 2 adds 0x2000 |
| tall | input | 1 | Sprite height select: 1 for 16 lines, 0 for 8 |
| snp_we | input | 1 | Snooped video-memory write strobe |
| snp_addr | input | 14 | Snooped write address |
| snp_data | input | 8 | Snooped write data |
| rd_en | output | 1 | Video-memory read request |
| rd_addr | output | 14 | Read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| dl_we | output | 1 | Draw entry valid |
| dl_slot | output | $clog2(DRAWS) | Draw entry number |
| dl_x | output | 8 | Sprite X position |
| dl_row | output | 14 | Pattern row address |
| done | output | 1 | Evaluation finished |
| overflow | output | 1 | Draw list overflow |

## Verification
The table walk runs one table under several lines, heights and pattern-base settings. It separates single hits from hits on the second comparison lane, 8-line from 16-line sprites, and a row offset computed as `L - y` from one taken against the current line. An all-zero cache after reset, evaluated at line 255, shows both the reset clearing and the wrap to line 0. A table where every entry hits shows the hit cap and overflow together. Directed runs then check three things: the 0xD0 terminator stopping the scan, snooped writes inside and outside the Y window, and a restart in the middle of a scan.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

    localparam logic [7:0] END_Y = 8'hD0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RD_X,
        ST_RD_PAT,
        ST_EMIT,
        ST_DONE
    } ev_state_e;

endpackage

// File: rtl/spr_ycache.sv
module spr_ycache #(
    parameter int ENTRIES = 64,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    tbl_page,
    input  logic          snp_we,
    input  logic [13:0]   snp_addr,
    input  logic [7:0]    snp_data,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    output logic [7:0]    ra_y,
    output logic [7:0]    rb_y
);

    logic [7:0] mem [ENTRIES];
    logic       in_win;

    // A write counts only when it hits the table page and the Y window
    assign in_win = snp_we && (snp_addr[13:8] == tbl_page)
                    && (snp_addr[7:0] < 8'(ENTRIES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (in_win) begin
            mem[snp_addr[IW-1:0]] <= snp_data;
        end
    end

    assign ra_y = mem[ra_idx];
    assign rb_y = mem[rb_idx];

    // R6: a write in the window is visible in the cache on the next cycle
    a_r6_snoop_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |=> mem[$past(snp_addr[IW-1:0])] == $past(snp_data));

endmodule

// File: rtl/spr_row_cmp.sv
module spr_row_cmp (
    input  logic [7:0] y,
    input  logic [7:0] line,
    input  logic       tall,
    output logic       hit
);

    logic [8:0] y_end;

    always_comb begin
        y_end = {1'b0, y} + (tall ? 9'd16 : 9'd8);
        hit   = (line >= y) && ({1'b0, line} < y_end);
    end

endmodule

// File: rtl/spr_hit_list.sv
module spr_hit_list #(
    parameter int HITS = 10,
    parameter int IW   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we_a,
    input  logic [IW-1:0]              idx_a,
    input  logic [7:0]                 y_a,
    input  logic                       we_b,
    input  logic [IW-1:0]              idx_b,
    input  logic [7:0]                 y_b,
    input  logic [$clog2(HITS+1)-1:0]  rd_ptr,
    output logic [IW-1:0]              rd_idx,
    output logic [7:0]                 rd_y,
    output logic [$clog2(HITS+1)-1:0]  cnt
);

    localparam int HW = $clog2(HITS + 1);

    logic [IW-1:0] idx_m [HITS];
    logic [7:0]    y_m   [HITS];
    logic [HW-1:0] cnt_q;
    logic [HW-1:0] slot_a;
    logic [HW-1:0] slot_b;

    assign slot_a = cnt_q;
    assign slot_b = cnt_q + HW'(we_a);

    for (genvar g = 0; g < HITS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_m[g] <= '0;
                y_m[g]   <= '0;
            end else if (we_a && (slot_a == HW'(g))) begin
                idx_m[g] <= idx_a;
                y_m[g]   <= y_a;
            end else if (we_b && (slot_b == HW'(g))) begin
                idx_m[g] <= idx_b;
                y_m[g]   <= y_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + HW'(we_a) + HW'(we_b);
    end

    always_comb begin
        if (32'(rd_ptr) < HITS) begin
            rd_idx = idx_m[rd_ptr];
            rd_y   = y_m[rd_ptr];
        end else begin
            rd_idx = '0;
            rd_y   = '0;
        end
    end

    assign cnt = cnt_q;

    // R4: never more recorded hits than slots
    a_r4_hit_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= HITS);

    // R10: a clear empties the list on the next cycle
    a_r10_list_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import spr_eval_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int HITS    = 10,
    parameter int DRAWS   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [7:0]                 line_cur,
    input  logic [7:0]                 tbl_reg,
    input  logic [7:0]                 pat_reg,
    input  logic                       tall,
    input  logic                       snp_we,
    input  logic [13:0]                snp_addr,
    input  logic [7:0]                 snp_data,
    output logic                       rd_en,
    output logic [13:0]                rd_addr,
    input  logic [7:0]                 rd_data,
    output logic                       dl_we,
    output logic [$clog2(DRAWS)-1:0]   dl_slot,
    output logic [7:0]                 dl_x,
    output logic [13:0]                dl_row,
    output logic                       done,
    output logic                       overflow
);

    localparam int IW = $clog2(ENTRIES);
    localparam int EW = IW + 1;
    localparam int HW = $clog2(HITS + 1);
    localparam int DW = $clog2(DRAWS);

    ev_state_e     state_q, state_d;
    logic [7:0]    line_q;
    logic [EW-1:0] idx_q;
    logic [HW-1:0] k_q;
    logic [7:0]    x_q;
    logic          ovf_q;

    logic [7:0]    lane_y [2];
    logic [1:0]    lane_hit;
    logic [IW-1:0] ra_idx, rb_idx;

    logic [HW-1:0] cnt;
    logic [IW-1:0] hl_idx;
    logic [7:0]    hl_y;

    logic          avail_a, term_a, hit_a;
    logic          avail_b, term_b, hit_b;
    logic [HW-1:0] cnt_a;
    logic [EW-1:0] step;
    logic          scan_stop;
    logic          scanning;
    logic          emit_last, emit_ovf;
    logic [7:0]    row_dy;

    logic          unused_cfg;
    assign unused_cfg = ^{tbl_reg[7], tbl_reg[0], pat_reg[7:3], pat_reg[1:0]};

    // ---------------- Y cache and comparison lanes ----------------
    assign ra_idx = idx_q[IW-1:0];
    assign rb_idx = idx_q[IW-1:0] + IW'(1);

    spr_ycache #(.ENTRIES(ENTRIES), .IW(IW)) i_ycache (
        .clk      (clk),
        .rst_n    (rst_n),
        .tbl_page (tbl_reg[6:1]),
        .snp_we   (snp_we),
        .snp_addr (snp_addr),
        .snp_data (snp_data),
        .ra_idx   (ra_idx),
        .rb_idx   (rb_idx),
        .ra_y     (lane_y[0]),
        .rb_y     (lane_y[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        spr_row_cmp i_cmp (
            .y    (lane_y[g]),
            .line (line_q),
            .tall (tall),
            .hit  (lane_hit[g])
        );
    end

    // ---------------- scan step decisions ----------------
    assign scanning = (state_q == ST_SCAN) && !start;

    always_comb begin
        avail_a   = (idx_q < EW'(ENTRIES)) && (cnt < HW'(HITS));
        term_a    = (lane_y[0] == END_Y);
        hit_a     = avail_a && !term_a && lane_hit[0];
        cnt_a     = cnt + HW'(hit_a);
        avail_b   = avail_a && !term_a && ((idx_q + EW'(1)) < EW'(ENTRIES))
                    && (cnt_a < HW'(HITS));
        term_b    = (lane_y[1] == END_Y);
        hit_b     = avail_b && !term_b && lane_hit[1];
        step      = EW'(avail_a && !term_a) + EW'(avail_b && !term_b);
        scan_stop = !avail_a || term_a;
    end

    spr_hit_list #(.HITS(HITS), .IW(IW)) i_hits (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .we_a   (scanning && hit_a),
        .idx_a  (ra_idx),
        .y_a    (lane_y[0]),
        .we_b   (scanning && hit_b),
        .idx_b  (rb_idx),
        .y_b    (lane_y[1]),
        .rd_ptr (k_q),
        .rd_idx (hl_idx),
        .rd_y   (hl_y),
        .cnt    (cnt)
    );

    // ---------------- fetch loop decisions ----------------
    assign emit_last = (32'(k_q) + 1) == 32'(cnt);
    assign emit_ovf  = !emit_last && ((32'(k_q) + 1) >= DRAWS);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SCAN:   if (scan_stop) state_d = (cnt == '0) ? ST_DONE : ST_RD_X;
                ST_RD_X:   state_d = ST_RD_PAT;
                ST_RD_PAT: state_d = ST_EMIT;
                ST_EMIT:   state_d = (emit_last || emit_ovf) ? ST_DONE : ST_RD_X;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            idx_q  <= '0;
            k_q    <= '0;
            x_q    <= '0;
            ovf_q  <= 1'b0;
        end else if (start) begin
            line_q <= line_cur + 8'd1;
            idx_q  <= '0;
            k_q    <= '0;
            ovf_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_SCAN:   if (!scan_stop) idx_q <= idx_q + step;
                ST_RD_PAT: x_q <= rd_data;
                ST_EMIT: begin
                    k_q <= k_q + HW'(1);
                    if (emit_ovf) ovf_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        rd_en    = (state_q == ST_RD_X) || (state_q == ST_RD_PAT);
        rd_addr  = {tbl_reg[6:1], 8'h80} + (14'(hl_idx) << 1)
                   + 14'(state_q == ST_RD_PAT);
        row_dy   = line_q - hl_y;
        dl_we    = (state_q == ST_EMIT);
        dl_slot  = DW'(k_q);
        dl_x     = x_q;
        dl_row   = {pat_reg[2], 13'd0} + {1'b0, rd_data, 5'd0}
                   + {8'd0, row_dy[3:0], 2'd0};
        done     = (state_q == ST_DONE);
        overflow = ovf_q;
    end

    // R7: reads stay in the attribute half of the table page
    a_r7_read_page: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[13:8] == tbl_reg[6:1]) && rd_addr[7]);

    // R7: an entry is only emitted right after a read was issued
    a_r7_emit_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        dl_we |-> $past(rd_en));

    // R9: overflow holds until the next start
    a_r9_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    // R9: no entry is emitted once overflow is flagged
    a_r9_no_emit_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        dl_we |-> !overflow);

    // R10: start clears the result flags
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!overflow && !done));

endmodule

// File: tb/test_sprite_line_eval.sv
module test_sprite_line_eval;

    localparam int ENTRIES = 64;
    localparam int HITS    = 10;
    localparam int DRAWS   = 8;
    localparam logic [7:0]  TBL  = 8'hBF;      // bits 6:1 -> page 0x1F
    localparam logic [13:0] BASE = 14'h1F00;
    localparam int NV = 8;
    // {line_cur, tall, pattern-base bit}
    localparam logic [9:0] VEC [NV] = '{
        {8'd16,  1'b0, 1'b0},
        {8'd19,  1'b1, 1'b1},
        {8'd19,  1'b0, 1'b0},
        {8'd10,  1'b0, 1'b1},
        {8'd255, 1'b1, 1'b0},
        {8'd50,  1'b1, 1'b1},
        {8'd120, 1'b0, 1'b0},
        {8'd200, 1'b1, 1'b0}
    };

    logic        clk, rst_n, start, tall, snp_we, rd_en, dl_we, done, overflow;
    logic [7:0]  line_cur, tbl_reg, pat_reg, snp_data, rd_data, dl_x;
    logic [13:0] snp_addr, rd_addr, dl_row;
    logic [2:0]  dl_slot;

    logic [7:0]  page [256];
    logic [7:0]  ymir [ENTRIES];
    int          compared, mismatched;
    int          cap_n;
    logic [7:0]  cap_x   [DRAWS];
    logic [13:0] cap_row [DRAWS];
    int          cap_slot[DRAWS];
    int          exp_n;
    logic [7:0]  exp_x   [DRAWS];
    logic [13:0] exp_row [DRAWS];
    logic        exp_ovf;

    sprite_line_eval #(.ENTRIES(ENTRIES), .HITS(HITS), .DRAWS(DRAWS)) i_sprite_line_eval (
        .clk(clk), .rst_n(rst_n), .start(start), .line_cur(line_cur),
        .tbl_reg(tbl_reg), .pat_reg(pat_reg), .tall(tall),
        .snp_we(snp_we), .snp_addr(snp_addr), .snp_data(snp_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .dl_we(dl_we), .dl_slot(dl_slot), .dl_x(dl_x), .dl_row(dl_row),
        .done(done), .overflow(overflow)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // video memory model: only the table page is stored
    always @(posedge clk) if (rd_en) rd_data <= page[rd_addr[7:0]];

    always @(negedge clk) begin
        if (dl_we) begin
            if (cap_n < DRAWS) begin
                cap_x[cap_n]    = dl_x;
                cap_row[cap_n]  = dl_row;
                cap_slot[cap_n] = int'(dl_slot);
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: run did not finish (act=running exp=finished)");
        summary();
        $finish;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic snoop_wr(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        snp_we = 1'b1; snp_addr = a; snp_data = d;
        @(negedge clk);
        snp_we = 1'b0;
        if (a[13:8] == BASE[13:8]) begin
            page[a[7:0]] = d;
            if (int'(a[7:0]) < ENTRIES) ymir[a[5:0]] = d;
        end
    endtask

    // reference: built from the requirements, not from the design
    task automatic model(input int lc, input bit t, input bit pb);
        int ln, h, nh;
        int hidx [HITS];
        int hy   [HITS];
        ln = (lc + 1) % 256;
        h  = t ? 16 : 8;
        nh = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (nh == HITS) break;
            if (ymir[i] == 8'hD0) break;
            if (int'(ymir[i]) <= ln && ln < int'(ymir[i]) + h) begin
                hidx[nh] = i; hy[nh] = int'(ymir[i]); nh++;
            end
        end
        exp_ovf = 1'b0;
        exp_n   = 0;
        for (int k = 0; k < nh; k++) begin
            if (k >= DRAWS) begin exp_ovf = 1'b1; break; end
            exp_x[k]   = page[8'h80 + 2*hidx[k]];
            exp_row[k] = 14'((pb ? 32'h2000 : 0) + 32 * int'(page[8'h81 + 2*hidx[k]])
                             + 4 * (ln - hy[k]));
            exp_n++;
        end
    endtask

    task automatic pulse_start(input int lc, input bit t, input bit pb);
        @(negedge clk);
        line_cur = 8'(lc); tall = t;
        pat_reg  = pb ? 8'hFF : 8'hFB;   // only bit 2 should matter (R8)
        start = 1'b1; cap_n = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_line(input int lc, input bit t, input bit pb, input string tag);
        int cyc;
        model(lc, t, pb);
        pulse_start(lc, t, pb);
        cyc = 0;
        while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
        check(tag, "done reached", int'(done), 1);
        check(tag, "entry count", cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            check(tag, "slot number", cap_slot[k], k);
            check(tag, "x", int'(cap_x[k]), int'(exp_x[k]));
            check(tag, "row address", int'(cap_row[k]), int'(exp_row[k]));
        end
        check(tag, "overflow", int'(overflow), int'(exp_ovf));
    endtask

    task automatic fill_table();
        for (int i = 0; i < ENTRIES; i++) begin
            logic [7:0] y;
            y = 8'((i * 37 + 11) % 256);
            if (y == 8'hD0) y = 8'hD1;
            snoop_wr(BASE + 14'(i), y);
            page[8'h80 + 2*i] = 8'(i * 3 + 1);
            page[8'h81 + 2*i] = 8'((i * 29 + 7) % 256);
        end
    endtask

    initial begin
        compared = 0; mismatched = 0; cap_n = 0;
        rst_n = 1'b0; start = 1'b0; tall = 1'b0; snp_we = 1'b0;
        line_cur = '0; tbl_reg = TBL; pat_reg = '0; snp_addr = '0; snp_data = '0;
        rd_data = '0;
        for (int i = 0; i < 256; i++) page[i] = '0;
        for (int i = 0; i < ENTRIES; i++) ymir[i] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "done in reset", int'(done), 0);
        check("R11", "overflow in reset", int'(overflow), 0);
        check("R11", "rd_en in reset", int'(rd_en), 0);
        check("R11", "dl_we in reset", int'(dl_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "done after reset", int'(done), 0);

        // R11 cache cleared, R1 wrap: line 255 compares line 0, all Y are 0
        run_line(255, 0, 0, "R11 R1 R9");

        fill_table();

        // main table walk
        for (int v = 0; v < NV; v++) begin
            run_line(int'(VEC[v][9:2]), VEC[v][1], VEC[v][0], "R1 R2 R3 R4 R7 R8");
        end

        // R6: writes outside the Y window are ignored
        snoop_wr(BASE + 14'h40, 8'd17);
        snoop_wr(14'h2005, 8'd17);
        snoop_wr(BASE + 14'h0085, 8'd17);
        run_line(16, 0, 0, "R6 ignored");
        // R6: a write inside the window is captured
        snoop_wr(BASE + 14'h05, 8'd15);
        run_line(16, 0, 1, "R6 captured");

        // R5: terminator stops the scan
        snoop_wr(BASE + 14'h03, 8'hD0);
        run_line(13, 0, 0, "R5");
        run_line(16, 1, 0, "R5");
        fill_table();

        // R9 and R4 cap: every entry hits
        for (int i = 0; i < ENTRIES; i++) snoop_wr(BASE + 14'(i), 8'h40);
        run_line(8'h40, 0, 1, "R9 R4");

        // R10: restart in mid scan
        fill_table();
        pulse_start(255, 1, 0);
        repeat (3) @(negedge clk);
        run_line(19, 1, 1, "R10");

        // R11: reset in mid run
        pulse_start(19, 1, 1);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "done mid reset", int'(done), 0);
        check("R11", "overflow mid reset", int'(overflow), 0);
        check("R11", "rd_en mid reset", int'(rd_en), 0);
        check("R11", "dl_we mid reset", int'(dl_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule